// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block takes a grayscale image as a raster-ordered stream of 8-bit samples, one sample per accepted handshake, and returns one result per sample in the same order. Two row stores keep the rows above the incoming sample, and a 3x3 register window slides along the row. From that window the block forms the horizontal and vertical gradient components and adds their absolute values. The sum is brought back into 0..255, either by clamping or by a right shift of three, chosen by a build parameter. The result is compared with a run-time threshold to give a one-bit edge map.

Frame geometry is set at run time by `cfg_width` and `cfg_height`. Both are latched when a sample with `in_sof` is accepted, and each may range from 3 up to the build maxima. Each result leaves the block once the sample one row plus one column after it has been accepted. After the last sample of a frame, the block emits the remaining W+1 results on its own.

Control is a three-state machine. ST_IDLE waits for a start-of-frame sample. ST_RUN takes the body of the frame. ST_FLUSH drains the trailing results. The transitions are:
- ST_IDLE to ST_RUN: a sample with `in_sof` is accepted.
- ST_RUN to ST_FLUSH: the sample at row H-1, column W-1 is accepted.
- ST_FLUSH to ST_IDLE: the (W+1)th trailing result enters the pipeline.

Top module: `sobel_edge_stream`

## Requirements
- R1: In ST_IDLE, `in_ready` is 1. Accepted samples with `in_sof`=0 are discarded. A sample with `in_sof`=1 becomes pixel (0,0) and latches `cfg_width`/`cfg_height`. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each frame of W x H samples yields exactly W*H results in raster order. `out_sof`=1 only on the first result, and `out_eol`=1 on every result in column W-1.
- R3: For an interior pixel, the magnitude is |Jx|+|Jy|, with a range of 0..2040. Jx applies the weights (-1,0,1),(-2,0,2),(-1,0,1) by rows, and Jy applies (-1,-2,-1),(0,0,0),(1,2,1).
- R4: With NORM=NORM_SAT, `out_grad` equals min(magnitude, 255).
- R5: With NORM=NORM_SHIFT, `out_grad` equals magnitude >> 3.
- R6: Pixels in row 0, row H-1, column 0 or column W-1 give `out_grad`=0 and `out_edge`=0 whatever the threshold.
- R7: For an interior pixel, `out_edge`=1 exactly when `out_grad` >= `cfg_thresh`, so a threshold of 0 marks every interior pixel.
- R8: While `out_valid`=1 and `out_ready`=0, all outputs hold their values. No result is lost or repeated under backpressure.
- R9: In the cycle after the last sample of a frame is accepted, `in_ready` is 0. It stays 0 until all trailing results have entered the pipeline.
- R10: In ST_RUN, `in_sof` is ignored, and a sample carrying it is processed as an ordinary pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | WW | Frame width, latched at start of frame (3..MAX_W) |
| cfg_height | input | HW | Frame height, latched at start of frame (3..MAX_H) |
| cfg_thresh | input | 8 | Edge threshold, applied when a result is formed |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts the input sample |
| in_pixel | input | 8 | Input grayscale sample |
| in_sof | input | 1 | Marks the first sample of a frame |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_grad | output | 8 | Normalised gradient |
| out_edge | output | 1 | Thresholded edge flag |
| out_sof | output | 1 | First result of the frame |
| out_eol | output | 1 | Last result of a row |

## Verification
The bench sends a step image whose magnitude of 1020 saturates. Under the saturating rule this gives 255; a design that truncated instead of clamping would return 252, and the shifting build must give 127.

A flat image with a threshold of 0 checks two things at once: every interior pixel must be flagged, and every border pixel must stay at 0. A design that let the threshold compare reach the border would light up the frame outline.

Random frames at the minimum 3x3 size and at the full build width check row-store indexing. They also check the trailing W+1 results, which a design with a wrong drain count would truncate or over-run into the next frame.

Random backpressure, input gaps, stray samples before the start marker and stray start markers mid-frame target lost or duplicated results and false frame restarts.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    typedef logic [7:0] pix_t;
    typedef pix_t [2:0][2:0] win_t;   // [row][col], row 0 = top, col 0 = left

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH
    } state_e;

    typedef enum logic {
        NORM_SAT,
        NORM_SHIFT
    } norm_e;

    localparam int MAG_W = 11;        // |Jx|+|Jy| <= 2040
endpackage

// File: rtl/sobel_rowstore.sv
module sobel_rowstore
    import sobel_pkg::*;
#(
    parameter int MAX_W = 640,
    localparam int IW = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          shift_en,
    input  logic [IW-1:0] col,
    input  pix_t          pix,
    output win_t          win
);
    pix_t row_near [MAX_W];
    pix_t row_far  [MAX_W];
    pix_t new_col  [3];

    always_comb begin
        new_col[0] = row_far[col];
        new_col[1] = row_near[col];
        new_col[2] = pix;
    end

    always_ff @(posedge clk) begin
        if (shift_en) begin
            row_far[col]  <= row_near[col];
            row_near[col] <= pix;
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_win_row
        always_ff @(posedge clk) begin
            if (shift_en) begin
                win[r][0] <= win[r][1];
                win[r][1] <= win[r][2];
                win[r][2] <= new_col[r];
            end
        end
    end
endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
#(
    parameter norm_e NORM = NORM_SAT
) (
    input  win_t       win,
    input  logic       zero,
    input  logic [7:0] thresh,
    output logic [7:0] grad,
    output logic       edge_flag
);
    logic [9:0] left_s, right_s, top_s, bot_s;
    logic [9:0] ax, ay;
    logic [MAG_W-1:0] mag;
    logic [7:0] norm_v;

    always_comb begin
        left_s  = {2'b0, win[0][0]} + {1'b0, win[1][0], 1'b0} + {2'b0, win[2][0]};
        right_s = {2'b0, win[0][2]} + {1'b0, win[1][2], 1'b0} + {2'b0, win[2][2]};
        top_s   = {2'b0, win[0][0]} + {1'b0, win[0][1], 1'b0} + {2'b0, win[0][2]};
        bot_s   = {2'b0, win[2][0]} + {1'b0, win[2][1], 1'b0} + {2'b0, win[2][2]};
        ax  = (right_s >= left_s) ? right_s - left_s : left_s - right_s;
        ay  = (bot_s >= top_s)    ? bot_s - top_s    : top_s - bot_s;
        mag = {1'b0, ax} + {1'b0, ay};
    end

    always_comb begin
        a_r3_mag_range: assert (mag <= MAG_W'(2040));
    end

    if (NORM == NORM_SHIFT) begin : g_shift
        assign norm_v = mag[MAG_W-1:3];
    end else begin : g_sat
        assign norm_v = (mag > MAG_W'(255)) ? 8'hFF : mag[7:0];
    end

    assign grad      = zero ? 8'd0 : norm_v;
    assign edge_flag = !zero && (norm_v >= thresh);
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int    MAX_W = 640,
    parameter int    MAX_H = 480,
    parameter norm_e NORM  = NORM_SAT,
    localparam int   WW = $clog2(MAX_W + 1),
    localparam int   HW = $clog2(MAX_H + 1),
    localparam int   IW = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic [7:0]    cfg_thresh,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_pixel,
    input  logic          in_sof,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_grad,
    output logic          out_edge,
    output logic          out_sof,
    output logic          out_eol
);
    state_e state, state_nx;

    logic [WW-1:0] w_q, ic, ocol, fl_cnt;
    logic [HW-1:0] h_q, ir;
    logic          sof_pend;

    // stage A: neighbourhood ready, stage B: output register
    logic a_vld, a_zero, a_sof, a_eol;
    logic o_vld, o_edge, o_sof, o_eol;
    logic [7:0] o_grad;

    logic accept, a_adv, a_free, push_pix, push_fl, push;
    logic row_last, frame_last, emit, border;
    logic [IW-1:0] wr_col;
    win_t win;
    logic [7:0] k_grad;
    logic k_edge;

    assign accept     = in_valid && in_ready;
    assign a_adv      = a_vld && (!o_vld || out_ready);
    assign a_free     = !a_vld || a_adv;
    assign row_last   = (ic == w_q - 1'b1);
    assign frame_last = row_last && (ir == h_q - 1'b1);
    assign emit       = (ir != '0) && !((ir == HW'(1)) && (ic == '0));
    assign border     = (ic <= WW'(1)) || (ir == HW'(1));
    assign push_pix   = accept && (state == ST_RUN) && emit;
    assign push_fl    = (state == ST_FLUSH) && a_free;
    assign push       = push_pix || push_fl;
    assign wr_col     = (state == ST_IDLE) ? '0 : ic[IW-1:0];

    // ready output of the state machine
    always_comb begin
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_RUN:   in_ready = a_free;
            ST_FLUSH: in_ready = 1'b0;
            default:  in_ready = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && in_sof) state_nx = ST_RUN;
            ST_RUN:   if (accept && frame_last) state_nx = ST_FLUSH;
            ST_FLUSH: if (push_fl && (fl_cnt == w_q)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame position and drain counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= WW'(3);
            h_q      <= HW'(3);
            ic       <= '0;
            ir       <= '0;
            fl_cnt   <= '0;
            ocol     <= '0;
            sof_pend <= 1'b0;
        end else begin
            if (accept && (state == ST_IDLE) && in_sof) begin
                w_q      <= cfg_width;
                h_q      <= cfg_height;
                ic       <= WW'(1);
                ir       <= '0;
                ocol     <= '0;
                fl_cnt   <= '0;
                sof_pend <= 1'b1;
            end else if (accept && (state == ST_RUN)) begin
                if (row_last) begin
                    ic <= '0;
                    ir <= ir + 1'b1;
                end else begin
                    ic <= ic + 1'b1;
                end
            end
            if (push) begin
                sof_pend <= 1'b0;
                ocol     <= (ocol == w_q - 1'b1) ? '0 : ocol + 1'b1;
            end
            if (push_fl) fl_cnt <= fl_cnt + 1'b1;
        end
    end

    // stage A
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld  <= 1'b0;
            a_zero <= 1'b1;
            a_sof  <= 1'b0;
            a_eol  <= 1'b0;
        end else if (push) begin
            a_vld  <= 1'b1;
            a_zero <= push_fl || border;
            a_sof  <= sof_pend;
            a_eol  <= (ocol == w_q - 1'b1);
        end else if (a_adv) begin
            a_vld  <= 1'b0;
        end
    end

    sobel_rowstore #(.MAX_W(MAX_W)) u_rows (
        .clk      (clk),
        .shift_en (accept && (state != ST_FLUSH)),
        .col      (wr_col),
        .pix      (in_pixel),
        .win      (win)
    );

    sobel_kernel #(.NORM(NORM)) u_kernel (
        .win       (win),
        .zero      (a_zero),
        .thresh    (cfg_thresh),
        .grad      (k_grad),
        .edge_flag (k_edge)
    );

    // stage B: output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_grad <= '0;
            o_edge <= 1'b0;
            o_sof  <= 1'b0;
            o_eol  <= 1'b0;
        end else if (a_adv) begin
            o_vld  <= 1'b1;
            o_grad <= k_grad;
            o_edge <= k_edge;
            o_sof  <= a_sof;
            o_eol  <= a_eol;
        end else if (out_ready) begin
            o_vld  <= 1'b0;
        end
    end

    assign out_valid = o_vld;
    assign out_grad  = o_grad;
    assign out_edge  = o_edge;
    assign out_sof   = o_sof;
    assign out_eol   = o_eol;

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_grad) && $stable(out_edge)
                                    && $stable(out_sof) && $stable(out_eol));

    a_r6_border_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_sof || out_eol) |-> (out_grad == 8'd0) && !out_edge);

    a_r9_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (state == ST_RUN) && frame_last |=> !in_ready);

    a_r2_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof |-> !out_eol);
endmodule

// File: tb/tb_sobel_edge_stream.sv
module tb_sobel_edge_stream;
    import sobel_pkg::*;

    localparam int MW = 64;
    localparam int MH = 64;
    localparam int WW = $clog2(MW + 1);
    localparam int HW = $clog2(MH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [WW-1:0] cfg_width = WW'(3);
    logic [HW-1:0] cfg_height = HW'(3);
    logic [7:0]    cfg_thresh = 8'd0;
    logic          in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
    logic [7:0]    in_pixel = 8'd0;
    logic          in_ready, out_valid, out_edge, out_sof, out_eol;
    logic [7:0]    out_grad;
    logic          sh_in_ready, sh_valid, sh_edge, sh_sof, sh_eol;
    logic [7:0]    sh_grad;

    sobel_edge_stream #(.MAX_W(MW), .MAX_H(MH), .NORM(NORM_SAT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_thresh(cfg_thresh), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_sof(in_sof), .out_valid(out_valid),
        .out_ready(out_ready), .out_grad(out_grad), .out_edge(out_edge),
        .out_sof(out_sof), .out_eol(out_eol));

    sobel_edge_stream #(.MAX_W(MW), .MAX_H(MH), .NORM(NORM_SHIFT)) dut_sh (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_thresh(cfg_thresh), .in_valid(in_valid), .in_ready(sh_in_ready),
        .in_pixel(in_pixel), .in_sof(in_sof), .out_valid(sh_valid),
        .out_ready(out_ready), .out_grad(sh_grad), .out_edge(sh_edge),
        .out_sof(sh_sof), .out_eol(sh_eol));

    int img [MH][MW];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mag_at(input int r, input int c);
        int lx, rx, ty, by, ax, ay;
        lx = img[r-1][c-1] + 2*img[r][c-1] + img[r+1][c-1];
        rx = img[r-1][c+1] + 2*img[r][c+1] + img[r+1][c+1];
        ty = img[r-1][c-1] + 2*img[r-1][c] + img[r-1][c+1];
        by = img[r+1][c-1] + 2*img[r+1][c] + img[r+1][c+1];
        ax = (rx >= lx) ? rx - lx : lx - rx;
        ay = (by >= ty) ? by - ty : ty - by;
        return ax + ay;
    endfunction

    function automatic bit is_border(input int r, input int c, input int w, input int h);
        return (r == 0) || (c == 0) || (r == h-1) || (c == w-1);
    endfunction

    function automatic int exp_grad(input int r, input int c, input int w, input int h, input bit shift);
        int m;
        if (is_border(r, c, w, h)) return 0;
        m = mag_at(r, c);
        if (shift) return m >> 3;
        return (m > 255) ? 255 : m;
    endfunction

    task automatic run_frame(input int w, input int h, input int thr, input int mode,
                             input int gap, input int bp, input bit junk, input bit midsof);
        int nin, idx_in, idx_out, junk_left, guard, err0;
        bit last_acc, hold_prev;
        int hg, he;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                case (mode)
                    1: img[r][c] = (c >= w/2) ? 255 : 0;
                    2: img[r][c] = 77;
                    3: img[r][c] = (r >= h/2) ? 255 : 0;
                    default: img[r][c] = int'($urandom % 256);
                endcase
        @(negedge clk);
        cfg_width  = WW'(w);
        cfg_height = HW'(h);
        cfg_thresh = 8'(thr);
        nin = w * h; idx_in = 0; idx_out = 0; guard = 0;
        junk_left = junk ? 2 : 0;
        last_acc = 0; hold_prev = 0; hg = 0; he = 0;
        err0 = errors;
        while (idx_out < nin && guard < 30000) begin
            if (guard != 0) @(negedge clk);
            guard++;
            if (junk_left > 0) begin
                in_valid = 1'b1; in_pixel = 8'hA5; in_sof = 1'b0;
            end else if (idx_in < nin && int'($urandom % 100) >= gap) begin
                in_valid = 1'b1;
                in_pixel = 8'(img[idx_in / w][idx_in % w]);
                in_sof   = (idx_in == 0) || (midsof && ($urandom % 6 == 0));
            end else begin
                in_valid = 1'b0; in_sof = 1'b0;
            end
            out_ready = (int'($urandom % 100) >= bp);
            #1;
            if (last_acc) chk(in_ready == 1'b0, "R9 in_ready after last sample", int'(in_ready), 0);
            last_acc = 0;
            if (hold_prev) begin
                chk(out_valid && int'(out_grad) == hg && int'(out_edge) == he,
                    "R8 output held under backpressure", int'(out_grad), hg);
            end
            hold_prev = out_valid && !out_ready;
            hg = int'(out_grad); he = int'(out_edge);
            if (out_valid && out_ready) begin
                int r, c, eg, es;
                bit bd, ee;
                r = idx_out / w; c = idx_out % w;
                bd = is_border(r, c, w, h);
                eg = exp_grad(r, c, w, h, 1'b0);
                es = exp_grad(r, c, w, h, 1'b1);
                ee = !bd && (eg >= thr);
                chk(int'(out_grad) == eg, bd ? "R6 border gradient" : "R3 R4 saturated gradient",
                    int'(out_grad), eg);
                chk(out_edge == ee, bd ? "R6 border edge flag" : "R7 edge threshold",
                    int'(out_edge), int'(ee));
                chk(out_sof == (idx_out == 0), "R2 start marker", int'(out_sof), int'(idx_out == 0));
                chk(out_eol == (c == w-1), "R2 end-of-line marker", int'(out_eol), int'(c == w-1));
                chk(sh_valid && int'(sh_grad) == es, "R5 shifted gradient", int'(sh_grad), es);
                chk(sh_edge == (!bd && es >= thr), "R7 edge threshold shifted build",
                    int'(sh_edge), int'(!bd && es >= thr));
                idx_out++;
            end
            if (in_valid && in_ready) begin
                if (junk_left > 0) junk_left--;
                else begin
                    if (idx_in == nin - 1) last_acc = 1;
                    idx_in++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        chk(idx_out == nin, "R2 result count", idx_out, nin);
        if (junk) chk(errors == err0, "R1 stray samples before start discarded", errors - err0, 0);
        if (midsof) chk(errors == err0, "R10 mid-frame start marker ignored", errors - err0, 0);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R2 no extra result after frame", int'(out_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        // step edge at minimum size: magnitude 1020 -> 255 / 127
        run_frame(3, 3, 128, 1, 0, 0, 1'b0, 1'b0);
        // flat image, threshold 0: interior flagged, border clear
        run_frame(6, 5, 0, 2, 0, 0, 1'b0, 1'b0);
        // horizontal edge with backpressure
        run_frame(7, 6, 200, 3, 20, 50, 1'b1, 1'b0);
        // full build width
        run_frame(MW, 4, 90, 0, 10, 30, 1'b0, 1'b0);
        for (int i = 0; i < 24; i++) begin
            run_frame(3 + int'($urandom % 14), 3 + int'($urandom % 12), int'($urandom % 256),
                      0, int'($urandom % 50), int'($urandom % 60),
                      1'($urandom % 2), 1'($urandom % 2));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule